// File: doc/BRIEF.md
# External Data Space Decoder with One-Way Enable

This block sits between an 8-bit processor core and its external-data address space. For every load or store the core issues, it classifies the 16-bit address into one of four targets: a cycle on the external memory bus, a select for a window of peripheral registers, a select for a 256-byte on-chip RAM held inside the block, or an unmapped gap. Read data from the chosen target is returned to the core one clock after the read strobe.

A single mapping control bit decides whether the on-chip targets are visible at all. Reset sets it, and while it is set the whole top of the space goes to the external bus. Software clears it through a one-bit special-function-register write port, and after that it cannot bring the bit back. Only another reset does that. Software can read the bit back at any time. Protection against stray writes is therefore one-sided: noise or a runaway program can only leave the on-chip targets enabled, never disable them. A build parameter removes the peripheral window, and its addresses then fall into the gap.

Top module: `xdata_decoder`

## Requirements
- R1: After reset the mapping bit reads back as 1, no target select is active and `cpu_rdata` is 00h.
- R2: While the mapping bit is 1, every access in F700h–FFFFh asserts `ext_req` in the same cycle and neither `periph_sel` nor `ram_sel`.
- R3: An access below F700h always asserts `ext_req` only, whatever the mapping bit holds.
- R4: While the mapping bit is 0 and the peripheral window is built, an access in F700h–F7FFh asserts `periph_sel` only.
- R5: While the mapping bit is 0, an access in FF00h–FFFFh asserts `ram_sel` only. A write stores `cpu_wdata` at index `cpu_addr[7:0]`, and a later read of that index returns the stored byte on `cpu_rdata` one cycle after the read strobe.
- R6: While the mapping bit is 0, an access in F800h–FEFFh asserts no select. A read there returns 00h, and a write there leaves every RAM byte unchanged.
- R7: An SFR write with data bit 0 clears the mapping bit from the next cycle on. An SFR write with data bit 1 never changes it. `sfr_rdata` always shows the current bit.
- R8: Repeated clearing writes leave the mapping bit at 0.
- R9: Once cleared, the mapping bit stays 0 until reset, and reset sets it back to 1.
- R10: One cycle after a read strobe, `cpu_rdata` holds the byte that was on `ext_rdata` or `periph_rdata` at that clock edge, according to the target. It keeps that value until the next read.
- R11: With the peripheral window removed, an enabled access in F700h–F7FFh behaves as the gap of R6: no select, and 00h on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Core external-data address |
| cpu_wdata | input | 8 | Core store data |
| cpu_rd | input | 1 | Core read strobe, one cycle per access |
| cpu_wr | input | 1 | Core write strobe, one cycle per access |
| sfr_wr | input | 1 | Write strobe for the mapping control bit |
| sfr_wdata | input | 1 | Value written to the mapping control bit (0 clears) |
| ext_rdata | input | 8 | Read data from the external bus |
| periph_rdata | input | 8 | Read data from the peripheral register window |
| ext_req | output | 1 | External bus cycle request |
| periph_sel | output | 1 | Peripheral register window select |
| ram_sel | output | 1 | On-chip RAM select |
| cpu_rdata | output | 8 | Read data returned to the core |
| sfr_rdata | output | 1 | Current value of the mapping control bit |

## Verification
The three selects are combinational in the address, the strobes and the registered mapping bit, so the bench samples them in the same cycle as the stimulus, shortly after it drives the inputs on the falling edge. Read data and the mapping bit each pass through one register. The bench samples them just after the rising edge that takes the strobe or the SFR write, and the reference model updates at that same edge. Two instances, with and without the peripheral window, get identical stimulus and are compared against the model in every cycle.

// File: rtl/xdd_pkg.sv
package xdd_pkg;

    localparam int XDD_DW = 8;

    typedef enum logic [1:0] {
        RG_EXT  = 2'd0,
        RG_PERI = 2'd1,
        RG_RAM  = 2'd2,
        RG_GAP  = 2'd3
    } region_e;

    typedef struct packed {
        region_e             src;
        logic [XDD_DW-1:0]   ext_cap;
        logic [XDD_DW-1:0]   peri_cap;
    } rd_state_t;

endpackage

// File: rtl/xdd_map_ctrl.sv
module xdd_map_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sfr_wr,
    input  logic sfr_wdata,
    output logic map_dis
);

    logic map_d, map_q;

    // Clear-only next state: a written 1 is never taken
    always_comb begin
        map_d = map_q;
        if (sfr_wr && !sfr_wdata) begin
            map_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= 1'b1;
        end else begin
            map_q <= map_d;
        end
    end

    assign map_dis = map_q;

endmodule

// File: rtl/xdd_addr_decode.sv
module xdd_addr_decode
    import xdd_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter bit                HAS_PERIPH = 1'b1,
    parameter logic [ADDR_W-1:0] PERI_LO    = 16'hF700,
    parameter logic [ADDR_W-1:0] PERI_HI    = 16'hF7FF,
    parameter logic [ADDR_W-1:0] RAM_LO     = 16'hFF00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_dis,
    output region_e           region
);

    logic peri_hit;

    generate
        if (HAS_PERIPH) begin : g_peri
            assign peri_hit = (addr >= PERI_LO) && (addr <= PERI_HI);
        end else begin : g_no_peri
            assign peri_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        if ((addr < PERI_LO) || map_dis) begin
            region = RG_EXT;
        end else if (peri_hit) begin
            region = RG_PERI;
        end else if (addr >= RAM_LO) begin
            region = RG_RAM;
        end else begin
            region = RG_GAP;
        end
    end

endmodule

// File: rtl/xdd_ram.sv
module xdd_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[idx];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/xdata_decoder.sv
module xdata_decoder
    import xdd_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter int              RAM_DEPTH  = 256,
    parameter bit              HAS_PERIPH = 1'b1,
    parameter int              PERI_BASE  = 'hF700,
    parameter int              PERI_SPAN  = 256,
    parameter logic [XDD_DW-1:0] GAP_FILL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [XDD_DW-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              sfr_wr,
    input  logic              sfr_wdata,
    input  logic [XDD_DW-1:0] ext_rdata,
    input  logic [XDD_DW-1:0] periph_rdata,
    output logic              ext_req,
    output logic              periph_sel,
    output logic              ram_sel,
    output logic [XDD_DW-1:0] cpu_rdata,
    output logic              sfr_rdata
);

    localparam int                RAM_AW  = $clog2(RAM_DEPTH);
    localparam logic [ADDR_W-1:0] PERI_LO = ADDR_W'(PERI_BASE);
    localparam logic [ADDR_W-1:0] PERI_HI = ADDR_W'(PERI_BASE + PERI_SPAN - 1);
    localparam logic [ADDR_W-1:0] RAM_LO  = ADDR_W'((1 << ADDR_W) - RAM_DEPTH);

    logic              map_dis;
    region_e           region;
    logic              access;
    logic [XDD_DW-1:0] ram_rdata;
    rd_state_t         st_d, st_q;

    xdd_map_ctrl u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .map_dis   (map_dis)
    );

    xdd_addr_decode #(
        .ADDR_W     (ADDR_W),
        .HAS_PERIPH (HAS_PERIPH),
        .PERI_LO    (PERI_LO),
        .PERI_HI    (PERI_HI),
        .RAM_LO     (RAM_LO)
    ) u_dec (
        .addr    (cpu_addr),
        .map_dis (map_dis),
        .region  (region)
    );

    xdd_ram #(
        .DEPTH (RAM_DEPTH),
        .DW    (XDD_DW)
    ) u_ram (
        .clk   (clk),
        .we    (cpu_wr && (region == RG_RAM)),
        .re    (cpu_rd && (region == RG_RAM)),
        .idx   (cpu_addr[RAM_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (ram_rdata)
    );

    assign access     = cpu_rd || cpu_wr;
    assign ext_req    = access && (region == RG_EXT);
    assign periph_sel = access && (region == RG_PERI);
    assign ram_sel    = access && (region == RG_RAM);
    assign sfr_rdata  = map_dis;

    // Read-return state: target of the last read plus captured bus data
    always_comb begin
        st_d = st_q;
        if (cpu_rd) begin
            st_d.src = region;
            if (region == RG_EXT) begin
                st_d.ext_cap = ext_rdata;
            end
            if (region == RG_PERI) begin
                st_d.peri_cap = periph_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{src: RG_GAP, ext_cap: '0, peri_cap: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.src)
            RG_EXT:  cpu_rdata = st_q.ext_cap;
            RG_PERI: cpu_rdata = st_q.peri_cap;
            RG_RAM:  cpu_rdata = ram_rdata;
            default: cpu_rdata = GAP_FILL;
        endcase
    end

endmodule

// File: rtl/xdd_checker.sv
module xdd_checker #(
    parameter int                ADDR_W     = 16,
    parameter bit                HAS_PERIPH = 1'b1,
    parameter logic [ADDR_W-1:0] PERI_LO    = 16'hF700,
    parameter logic [ADDR_W-1:0] PERI_HI    = 16'hF7FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              sfr_wr,
    input logic              sfr_wdata,
    input logic              map_bit,
    input logic              ext_req,
    input logic              periph_sel,
    input logic              ram_sel
);

    p_reset_set_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> map_bit);

    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_req, periph_sel, ram_sel}));

    p_locked_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && map_bit) |-> (ext_req && !periph_sel && !ram_sel));

    p_low_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && (cpu_addr < PERI_LO)) |-> ext_req);

    p_peri_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && !map_bit && (cpu_addr >= PERI_LO) && (cpu_addr <= PERI_HI))
        |-> (periph_sel == HAS_PERIPH));

    p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && !sfr_wdata) |=> !map_bit);

    p_stays_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !map_bit |=> !map_bit);

endmodule

bind xdata_decoder xdd_checker #(
    .ADDR_W     (ADDR_W),
    .HAS_PERIPH (HAS_PERIPH),
    .PERI_LO    (PERI_LO),
    .PERI_HI    (PERI_HI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .sfr_wr     (sfr_wr),
    .sfr_wdata  (sfr_wdata),
    .map_bit    (sfr_rdata),
    .ext_req    (ext_req),
    .periph_sel (periph_sel),
    .ram_sel    (ram_sel)
);

// File: tb/xdata_decoder_tb.sv
module xdata_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        sfr_wr = 1'b0;
    logic        sfr_wdata = 1'b0;
    logic [7:0]  ext_rdata = '0;
    logic [7:0]  periph_rdata = '0;

    logic        ext_req_o    [2];
    logic        periph_sel_o [2];
    logic        ram_sel_o    [2];
    logic [7:0]  cpu_rdata_o  [2];
    logic        sfr_rdata_o  [2];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int pat = 0;

    // reference model state
    bit          m_map [2];
    logic [7:0]  m_rd  [2];
    int          m_src [2];
    logic [7:0]  m_mem [256];

    always #5 clk = ~clk;

    xdata_decoder #(.HAS_PERIPH(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .ext_rdata(ext_rdata), .periph_rdata(periph_rdata),
        .ext_req(ext_req_o[0]), .periph_sel(periph_sel_o[0]), .ram_sel(ram_sel_o[0]),
        .cpu_rdata(cpu_rdata_o[0]), .sfr_rdata(sfr_rdata_o[0])
    );

    xdata_decoder #(.HAS_PERIPH(1'b0)) u_dut_np (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .ext_rdata(ext_rdata), .periph_rdata(periph_rdata),
        .ext_req(ext_req_o[1]), .periph_sel(periph_sel_o[1]), .ram_sel(ram_sel_o[1]),
        .cpu_rdata(cpu_rdata_o[1]), .sfr_rdata(sfr_rdata_o[1])
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // 0 external, 1 peripheral, 2 RAM, 3 gap
    function automatic int m_region(logic [15:0] a, bit map, bit hasp);
        if (a < 16'hF700 || map) return 0;
        if (hasp && a <= 16'hF7FF) return 1;
        if (a >= 16'hFF00) return 2;
        return 3;
    endfunction

    function automatic string m_tag(int rg, logic [15:0] a, int k);
        if (rg == 0) return (a < 16'hF700) ? "R3" : "R2";
        if (rg == 1) return "R4";
        if (rg == 2) return "R5";
        return (k == 1 && a <= 16'hF7FF) ? "R11" : "R6";
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic cyc(logic [15:0] a, logic [7:0] wd, bit rd, bit wr,
                       bit sw, bit swd, string stag);
        @(negedge clk);
        pat++;
        cpu_addr = a; cpu_wdata = wd; cpu_rd = rd; cpu_wr = wr;
        sfr_wr = sw; sfr_wdata = swd;
        ext_rdata = 8'h3C ^ 8'(pat * 7);
        periph_rdata = 8'hA5 + 8'(pat);
        #1;
        for (int k = 0; k < 2; k++) begin
            int rg = m_region(a, m_map[k], k == 0);
            string t = m_tag(rg, a, k);
            bit acc = rd || wr;
            check({t, " ext_req"},    {7'b0, ext_req_o[k]},    {7'b0, acc && rg == 0});
            check({t, " periph_sel"}, {7'b0, periph_sel_o[k]}, {7'b0, acc && rg == 1});
            check({t, " ram_sel"},    {7'b0, ram_sel_o[k]},    {7'b0, acc && rg == 2});
        end
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            int rg = m_region(a, m_map[k], k == 0);
            if (rd) begin
                m_src[k] = rg;
                case (rg)
                    0:       m_rd[k] = ext_rdata;
                    1:       m_rd[k] = periph_rdata;
                    2:       m_rd[k] = m_mem[a[7:0]];
                    default: m_rd[k] = 8'h00;
                endcase
            end
        end
        if (wr && m_region(a, m_map[0], 1'b1) == 2) m_mem[a[7:0]] = wd;
        for (int k = 0; k < 2; k++) begin
            if (sw && !swd) m_map[k] = 1'b0;
        end
        #1;
        for (int k = 0; k < 2; k++) begin
            string rt = (m_src[k] == 2) ? "R5" : (m_src[k] == 3) ? "R6" : "R10";
            check({rt, " cpu_rdata"}, cpu_rdata_o[k], m_rd[k]);
            check({stag, " sfr_rdata"}, {7'b0, sfr_rdata_o[k]}, {7'b0, m_map[k]});
        end
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0;
        cpu_rd = 1'b0; cpu_wr = 1'b0; sfr_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 2; k++) begin
            m_map[k] = 1'b1; m_src[k] = 3; m_rd[k] = 8'h00;
        end
        #1;
        for (int k = 0; k < 2; k++) begin
            check({tag, " map bit after reset"}, {7'b0, sfr_rdata_o[k]}, 8'h01);
            check({tag, " rdata after reset"}, cpu_rdata_o[k], 8'h00);
            check({tag, " no select after reset"},
                  {5'b0, ext_req_o[k], periph_sel_o[k], ram_sel_o[k]}, 8'h00);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset("R1");

        // R2, R3: mapping bit set, all goes external
        foreach (m_mem[i]) m_mem[i] = 8'hxx;
        for (int i = 0; i < 9; i++) begin
            logic [15:0] a;
            case (i)
                0: a = 16'h0000; 1: a = 16'h1234; 2: a = 16'hF6FF;
                3: a = 16'hF700; 4: a = 16'hF7FF; 5: a = 16'hF800;
                6: a = 16'hFEFF; 7: a = 16'hFF00; default: a = 16'hFFFF;
            endcase
            cyc(a, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
            cyc(a, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
        end

        // R7: writing 1 while set changes nothing, writing 0 clears
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R7");

        // R5: RAM writes then reads, indexed by low byte
        for (int i = 0; i < 16; i++)
            cyc(16'hFF00 + 16'(i * 17), 8'hC0 ^ 8'(i * 3), 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        for (int i = 15; i >= 0; i--)
            cyc(16'hFF00 + 16'(i * 17), 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R5");

        // R4, R11: peripheral window on both builds
        cyc(16'hF700, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        cyc(16'hF780, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        cyc(16'hF7FF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        cyc(16'hF710, 8'h77, 1'b0, 1'b1, 1'b0, 1'b0, "R4");

        // R10: external read data held across non-read cycles
        cyc(16'h4000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
        cyc(16'h4001, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R10");

        // R6: gap reads and a gap write aliasing a RAM index
        cyc(16'hF800, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        cyc(16'hFA55, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        cyc(16'hFEFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        cyc(16'hF811, 8'hEE, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        cyc(16'hF722, 8'hDD, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
        cyc(16'hFF11, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        cyc(16'hFF22, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R11");

        // R7, R9: writing 1 after clearing has no effect
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        cyc(16'hFF33, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R9");

        // R8: repeated clears
        cyc(16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        cyc(16'hFF44, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
        cyc(16'hF7AA, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R8");

        // R3: low space stays external while enabled
        cyc(16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
        cyc(16'hF6FF, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        cyc(16'h8000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R3");

        // R9: only reset sets the bit again
        do_reset("R9");
        cyc(16'hFF00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        cyc(16'hF700, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R9");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule